// File: doc/BRIEF.md
# Single-Cycle Register-Machine Core

This block is a small non-pipelined processor. Each clock it fetches one 32-bit instruction word from an instruction memory at the address held in its program counter. It decodes the word, reads up to two operands from a register file and finishes the whole instruction before the next edge. The instruction can write a register, write the data memory, or redirect the program counter. Both memory ports are read combinationally, so the memories outside the core must answer within the same cycle. A write to data memory takes effect at the clock edge that closes the storing instruction.

The instruction set has six operations and a halt code. The six operations are: load an immediate constant, copy the current instruction address into a register, a two-source ALU operation, a conditional jump through a register, and a memory load and store. The jump is taken when a tested register is zero, and its target comes from a second register. There is no immediate branch offset. Program loops are built from a constant that holds a loop address and a register that is always zero.

Every word has the opcode in bits [31:28]. The 8-bit fields sit at [27:20] (field A), [19:12] (field B) and [11:4] (field C), and a 4-bit function code sits at [3:0]. A register field that names an index at or above the register count reads as zero, and a write to such an index is dropped.

Top module: `step_core`

## Requirements
- R1: Opcode 0 writes the 20-bit field [19:0], zero-extended, into the register named by field A, and the PC advances by one.
- R2: Opcode 1 writes the address of the instruction itself (the PC value before the increment) into the register named by field A, and the PC advances by one.
- R3: Opcode 2 writes f(reg[B], reg[C]) into reg[A]. The function code selects f: 0 add, 1 subtract (B minus C), 2 and, 3 or, 4 xor, 5 signed less-than (result 1 or 0), 6 equality (result 1 or 0). Codes 7 to 15 give zero. The PC advances by one.
- R4: Opcode 3 tests reg[A]. When it is zero the next PC is the value of reg[B]. Otherwise the next PC is PC+1. No register or memory is written.
- R5: Opcode 4 drives reg[B] on the data address output and writes the data read back into reg[A]. The PC advances by one.
- R6: Opcode 5 raises the write strobe for exactly that cycle, with reg[A] as the data address and reg[B] as the write data. No register changes. No other opcode raises the strobe.
- R7: Exactly one instruction completes per clock, in program order. Opcodes 6 to 14 change nothing except advancing the PC by one.
- R8: Opcode 15 is a halt. From the next cycle on, the halt output is high, the PC stays at the halt address, and no register or memory write happens until reset.
- R9: While the active-low synchronous reset is low at a clock edge, the PC, every register and the halt flag clear to zero.
- R10: Register fields at or above the register count (16 by default) read as zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | DATA_W | Program counter, the instruction fetch address |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | DATA_W | Data memory address for load or store |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | DATA_W | Data to be written on a store |
| dmem_rdata | input | DATA_W | Data read at dmem_addr, same cycle |
| halted | output | 1 | High once a halt instruction has been executed |

## Verification
The first program builds one negative and one positive operand. It sends them through every ALU function code, including the unused codes, and stores each result. This separates signed from unsigned comparison and the order of subtraction, and it shows whether any result leaks into the wrong register. The second program runs a countdown loop through the register-held jump target, taken and not taken, with a zero register used as an unconditional jump. Within the same run it performs a load and a store-back, executes undefined opcodes, and halts. This tells apart a jump that reads the wrong field, or an off-by-one loop exit, from a correct one. Stores of never-written and out-of-range registers reveal reset clearing and index masking at the data port.

// File: rtl/step_pkg.sv
// Shared opcode values, field widths and control types for the core.
// Assumes a fixed 32-bit instruction word with a 4-bit opcode on top.
package step_pkg;

    localparam int INSTR_W = 32;
    localparam int FIELD_W = 8;
    localparam int IMM_W   = 20;
    localparam int FUNC_W  = 4;

    localparam logic [3:0] OP_LDC  = 4'd0;
    localparam logic [3:0] OP_LDPC = 4'd1;
    localparam logic [3:0] OP_ALU  = 4'd2;
    localparam logic [3:0] OP_JZ   = 4'd3;
    localparam logic [3:0] OP_LD   = 4'd4;
    localparam logic [3:0] OP_ST   = 4'd5;
    localparam logic [3:0] OP_HALT = 4'd15;

    localparam logic [FUNC_W-1:0] FN_ADD = 4'd0;
    localparam logic [FUNC_W-1:0] FN_SUB = 4'd1;
    localparam logic [FUNC_W-1:0] FN_AND = 4'd2;
    localparam logic [FUNC_W-1:0] FN_OR  = 4'd3;
    localparam logic [FUNC_W-1:0] FN_XOR = 4'd4;
    localparam logic [FUNC_W-1:0] FN_SLT = 4'd5;
    localparam logic [FUNC_W-1:0] FN_SEQ = 4'd6;

    typedef enum logic [1:0] {
        WB_IMM = 2'd0,
        WB_PC  = 2'd1,
        WB_ALU = 2'd2,
        WB_MEM = 2'd3
    } wb_sel_e;

    typedef struct packed {
        logic    rf_we;
        wb_sel_e wsel;
        logic    mem_we;
        logic    is_jz;
        logic    is_halt;
    } ctrl_t;

endpackage

// File: rtl/step_decode.sv
// Instruction decoder: splits the word into register indices, function
// code and immediate, and produces the control bundle.
// Assumes opcodes 6..14 are no-operations (all controls low).
module step_decode
    import step_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [FIELD_W-1:0] rd_idx,
    output logic [FIELD_W-1:0] ra_idx,
    output logic [FIELD_W-1:0] rb_idx,
    output logic [FUNC_W-1:0]  func,
    output logic [IMM_W-1:0]   imm
);

    logic [3:0] op;
    logic       fields_shifted;

    assign op     = instr[31:28];
    assign rd_idx = instr[27:20];
    assign func   = instr[3:0];
    assign imm    = instr[19:0];

    // Jump and store read their operands one field further up.
    assign fields_shifted = (op == OP_JZ) || (op == OP_ST);
    assign ra_idx = fields_shifted ? instr[27:20] : instr[19:12];
    assign rb_idx = fields_shifted ? instr[19:12] : instr[11:4];

    // Control generation per opcode.
    always_comb begin
        ctrl = '0;
        case (op)
            OP_LDC:  begin ctrl.rf_we = 1'b1; ctrl.wsel = WB_IMM; end
            OP_LDPC: begin ctrl.rf_we = 1'b1; ctrl.wsel = WB_PC;  end
            OP_ALU:  begin ctrl.rf_we = 1'b1; ctrl.wsel = WB_ALU; end
            OP_LD:   begin ctrl.rf_we = 1'b1; ctrl.wsel = WB_MEM; end
            OP_ST:   ctrl.mem_we  = 1'b1;
            OP_JZ:   ctrl.is_jz   = 1'b1;
            OP_HALT: ctrl.is_halt = 1'b1;
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/step_regfile.sv
// Register file with two combinational read ports and one write port.
// Assumes NREG <= 2**IDX_W; indices at or above NREG read zero and
// writes to them are dropped. Synchronous active-low reset clears all.
module step_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One storage word: cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (waddr == IDX_W'(g)))
                regs[g] <= wdata;
        end
    end

    // Port A selection; unmatched indices yield zero.
    always_comb begin
        rdata_a = '0;
        for (int i = 0; i < NREG; i++)
            if (raddr_a == IDX_W'(i)) rdata_a = regs[i];
    end

    // Port B selection; unmatched indices yield zero.
    always_comb begin
        rdata_b = '0;
        for (int i = 0; i < NREG; i++)
            if (raddr_b == IDX_W'(i)) rdata_b = regs[i];
    end

endmodule

// File: rtl/step_alu.sv
// Combinational ALU for the register-register operation.
// Assumes operands are two's complement for the less-than compare;
// unused function codes return zero.
module step_alu
    import step_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FUNC_W-1:0] func,
    output logic [DATA_W-1:0] y
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Result selection by function code.
    always_comb begin
        case (func)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SLT:  y = ($signed(a) < $signed(b)) ? ONE : '0;
            FN_SEQ:  y = (a == b) ? ONE : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/step_core.sv
// Single-cycle core top: PC and halt state, fetch, decode, register
// read, ALU, write-back and next-PC choice, all within one clock.
// Assumes both memories answer combinationally; the data memory
// captures a store at the rising edge closing the store cycle.
module step_core
    import step_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [DATA_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [DATA_W-1:0]  dmem_addr,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic               halted
);

    localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(1);

    logic [DATA_W-1:0]  pc, pc_next;
    logic               halt_q;
    ctrl_t              ctrl;
    logic [FIELD_W-1:0] rd_idx, ra_idx, rb_idx;
    logic [FUNC_W-1:0]  func;
    logic [IMM_W-1:0]   imm;
    logic [DATA_W-1:0]  rdata_a, rdata_b, alu_y, wb_data;
    logic               rf_we;

    step_decode u_dec (
        .instr  (imem_data),
        .ctrl   (ctrl),
        .rd_idx (rd_idx),
        .ra_idx (ra_idx),
        .rb_idx (rb_idx),
        .func   (func),
        .imm    (imm)
    );

    step_regfile #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(FIELD_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rd_idx),
        .wdata   (wb_data),
        .raddr_a (ra_idx),
        .rdata_a (rdata_a),
        .raddr_b (rb_idx),
        .rdata_b (rdata_b)
    );

    step_alu #(.DATA_W(DATA_W)) u_alu (
        .a    (rdata_a),
        .b    (rdata_b),
        .func (func),
        .y    (alu_y)
    );

    assign imem_addr  = pc;
    assign halted     = halt_q;
    assign dmem_addr  = rdata_a;
    assign dmem_wdata = rdata_b;
    assign dmem_we    = ctrl.mem_we && !halt_q;
    assign rf_we      = ctrl.rf_we && !halt_q;

    // Write-back source selection.
    always_comb begin
        case (ctrl.wsel)
            WB_IMM:  wb_data = {{(DATA_W-IMM_W){1'b0}}, imm};
            WB_PC:   wb_data = pc;
            WB_ALU:  wb_data = alu_y;
            default: wb_data = dmem_rdata;
        endcase
    end

    // Next-PC choice: hold on halt, register target on zero test, else step.
    always_comb begin
        if (halt_q || ctrl.is_halt)
            pc_next = pc;
        else if (ctrl.is_jz && (rdata_a == '0))
            pc_next = rdata_b;
        else
            pc_next = pc + PC_STEP;
    end

    // Architectural PC and halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halt_q <= 1'b0;
        end else begin
            pc     <= pc_next;
            halt_q <= halt_q || ctrl.is_halt;
        end
    end

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && !ctrl.is_jz && !ctrl.is_halt) |=> (pc == $past(pc) + PC_STEP));

    // R4
    jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && ctrl.is_jz && (rdata_a == '0)) |=> (pc == $past(rdata_b)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q || ctrl.is_halt) |=> (halt_q && $stable(pc)));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |-> (!rf_we && !dmem_we));

    // R6
    store_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && dmem_we));

endmodule

// File: tb/test_step_core.sv
// Bench: behavioural instruction-level model stepped every clock and
// compared at the falling edge with the core's outputs.
module test_step_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, halted;

    logic [31:0] rom [64];
    logic [31:0] ram [256];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [31:0] m_reg [16];
    string       m_tag [16];
    logic [31:0] m_ram [256];
    logic [31:0] m_pc;
    bit          m_halt;
    string       m_last;

    always #2 clk = ~clk;

    assign imem_data  = rom[imem_addr[5:0]];
    assign dmem_rdata = ram[dmem_addr[7:0]];

    always @(posedge clk) if (dmem_we) ram[dmem_addr[7:0]] <= dmem_wdata;

    step_core i_step_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .halted(halted)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] e_ldc(int rd, int imm);
        return {4'd0, 8'(rd), 20'(imm)};
    endfunction
    function automatic logic [31:0] e_ldpc(int rd);
        return {4'd1, 8'(rd), 20'd0};
    endfunction
    function automatic logic [31:0] e_alu(int rd, int a, int b, int f);
        return {4'd2, 8'(rd), 8'(a), 8'(b), 4'(f)};
    endfunction
    function automatic logic [31:0] e_jz(int t, int g);
        return {4'd3, 8'(t), 8'(g), 12'd0};
    endfunction
    function automatic logic [31:0] e_ld(int rd, int a);
        return {4'd4, 8'(rd), 8'(a), 12'd0};
    endfunction
    function automatic logic [31:0] e_st(int a, int d);
        return {4'd5, 8'(a), 8'(d), 12'd0};
    endfunction
    function automatic logic [31:0] e_raw(int op);
        return {4'(op), 28'd0};
    endfunction

    function automatic logic [31:0] rdv(logic [7:0] i);
        return (i < 16) ? m_reg[i[3:0]] : 32'd0;
    endfunction
    function automatic string rdt(logic [7:0] i);
        return (i < 16) ? m_tag[i[3:0]] : "R10";
    endfunction

    task automatic wr(logic [7:0] i, logic [31:0] v, string t);
        if (i < 16) begin
            m_reg[i[3:0]] = v;
            m_tag[i[3:0]] = t;
        end
    endtask

    function automatic logic [31:0] m_alu(logic [31:0] a, logic [31:0] b, logic [3:0] f);
        case (f)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd6: return (a == b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    // Compare this cycle's outputs, then advance the model by one instruction.
    task automatic compare_and_step();
        logic [31:0] ins;
        logic [3:0]  op;
        logic [7:0]  fa, fb, fc;
        bit          exp_we;
        ins = rom[m_pc[5:0]];
        op = ins[31:28]; fa = ins[27:20]; fb = ins[19:12]; fc = ins[11:4];
        exp_we = !m_halt && (op == 4'd5);
        chk(m_last, "pc", imem_addr, m_pc);
        chk("R8", "halted", {31'd0, halted}, {31'd0, m_halt});
        chk("R6", "we", {31'd0, dmem_we}, {31'd0, exp_we});
        if (exp_we && dmem_we) begin
            chk("R6", "st addr", dmem_addr, rdv(fa));
            chk(rdt(fb), "st data", dmem_wdata, rdv(fb));
        end
        if (m_halt) return;
        m_last = "R7";
        case (op)
            4'd0: wr(fa, {12'd0, ins[19:0]}, "R1");
            4'd1: wr(fa, m_pc, "R2");
            4'd2: wr(fa, m_alu(rdv(fb), rdv(fc), ins[3:0]), "R3");
            4'd4: wr(fa, m_ram[rdv(fb) & 32'hFF], "R5");
            4'd5: m_ram[rdv(fa) & 32'hFF] = rdv(fb);
            default: ;
        endcase
        if (op == 4'd15) begin
            m_halt = 1'b1;
            m_last = "R8";
        end else if (op == 4'd3) begin
            m_last = "R4";
            m_pc = (rdv(fa) == 0) ? rdv(fb) : m_pc + 1;
        end else begin
            m_pc = m_pc + 1;
        end
    endtask

    task automatic run_prog(int cycles);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "reset pc", imem_addr, 32'd0);
        chk("R9", "reset halted", {31'd0, halted}, 32'd0);
        chk("R9", "reset we", {31'd0, dmem_we}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            m_reg[i] = 32'd0;
            m_tag[i] = "R9";
        end
        for (int i = 0; i < 256; i++) m_ram[i] = ram[i];
        m_pc = 32'd0; m_halt = 1'b0; m_last = "R9";
        rst_n = 1'b1;
        #1;
        for (int c = 0; c < cycles; c++) begin
            compare_and_step();
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < 256; i++) ram[i] = 32'd0;
        // program A: constants, PC copy, every ALU code, index masking
        for (int i = 0; i < 64; i++) rom[i] = e_raw(15);
        rom[0] = e_ldc(1, 7);
        rom[1] = e_ldc(2, 12);
        rom[2] = e_alu(3, 1, 2, 1);
        rom[3] = e_ldc(5, 1);
        rom[4] = e_ldc(6, 64);
        rom[5] = e_ldpc(7);
        rom[6] = e_st(6, 7);
        n = 7;
        for (int f = 0; f < 9; f++) begin
            rom[n]   = e_alu(4, 3, 2, f);
            rom[n+1] = e_st(6, 4);
            rom[n+2] = e_alu(6, 6, 5, 0);
            n += 3;
        end
        rom[n]   = e_alu(4, 1, 1, 6);
        rom[n+1] = e_st(6, 4);
        rom[n+2] = e_st(6, 0);
        rom[n+3] = e_ldc(200, 5);
        rom[n+4] = e_st(6, 200);
        rom[n+5] = e_ldc(8, 20'hFFFFF);
        rom[n+6] = e_st(6, 8);
        run_prog(60);

        // program B: register-target loop, load, undefined opcodes, halt
        for (int i = 0; i < 64; i++) rom[i] = e_raw(15);
        ram[200] = 32'hDEADBEEF;
        rom[0]  = e_ldc(1, 3);
        rom[1]  = e_ldc(2, 1);
        rom[2]  = e_ldc(3, 9);
        rom[3]  = e_ldc(5, 5);
        rom[4]  = e_ldpc(11);
        rom[5]  = e_alu(1, 1, 2, 1);
        rom[6]  = e_jz(1, 3);
        rom[7]  = e_jz(0, 5);
        rom[8]  = e_raw(15);
        rom[9]  = e_ldc(6, 200);
        rom[10] = e_ld(7, 6);
        rom[11] = e_ldc(9, 201);
        rom[12] = e_st(9, 7);
        rom[13] = e_raw(6);
        rom[14] = e_raw(14);
        rom[15] = e_st(9, 11);
        rom[16] = e_st(9, 1);
        rom[17] = e_jz(2, 0);
        rom[18] = e_raw(15);
        run_prog(50);
        chk("R5", "ram[201]", ram[201], m_ram[201]);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R7 watchdog act=%h exp=%h", 32'd1, 32'd0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule